// File: doc/BRIEF.md
# Cross-Clock Memory Request Bridge

This block connects a processor running on a fast clock to a memory controller running on a slower clock. The two clocks may come from a divider or from unrelated sources, so no phase relationship between them is assumed. The processor launches a read or a write with a 32-bit address and 32-bit write data. The bridge carries it to the memory side as a level request. It turns the controller's one-cycle completion pulse into a single completion pulse on the processor side, returning the read data with it.

Every transfer uses a four-phase handshake. A request level crosses into the memory domain through a chain of synchronizer flops. The memory side converts the controller's done pulse into an acknowledge level. That level is held until the synchronized request falls, and it crosses back the same way. Address, write data and direction are held in registers from launch until the handshake has fully closed. Read data is captured in the memory domain. The processor domain samples it only after the acknowledge has arrived. The memory side cannot start a new access until the request has been withdrawn, so the controller never sees a stale or repeated request.

Top module: `xclk_mem_bridge`

## Requirements
- R1: While either reset is low, cpu_busy, cpu_done, mem_rd_req and mem_wr_req are all 0.
- R2: A launch pulse (cpu_rd or cpu_wr high) seen on a processor clock edge while cpu_busy is 0 is accepted, and cpu_busy reads 1 from that edge on.
- R3: cpu_rd or cpu_wr seen while cpu_busy is 1 has no effect: the held address, data and direction of the transfer in flight do not change, and no extra memory access is made.
- R4: If cpu_rd and cpu_wr are both high at an accepted launch, the transfer is a read. During an access exactly one of mem_rd_req or mem_wr_req is 1, matching the direction. mem_addr and mem_wdata equal the launched values and stay stable while the request is high.
- R5: mem_rd_req and mem_wr_req fall on the first memory clock edge that samples mem_done high.
- R6: Each accepted launch causes exactly one memory access (one rising edge of mem_rd_req or mem_wr_req). No new access starts until the processor-side request has been withdrawn.
- R7: Each accepted launch produces exactly one cpu_done pulse, one processor clock cycle wide.
- R8: For a read, cpu_rdata equals the mem_rdata value present with mem_done, and it is valid while cpu_done is 1.
- R9: cpu_busy stays 1 through the cpu_done cycle. It returns to 0 only after the returned acknowledge has gone low, and only then is a new launch accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor domain clock |
| cpu_rst_n | input | 1 | Processor domain active-low reset |
| cpu_rd | input | 1 | Launch a read (wins over cpu_wr) |
| cpu_wr | input | 1 | Launch a write |
| cpu_addr | input | 32 | Transfer address |
| cpu_wdata | input | 32 | Write data |
| cpu_busy | output | 1 | Transfer in flight; launches ignored |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| mem_clk | input | 1 | Memory domain clock |
| mem_rst_n | input | 1 | Memory domain active-low reset |
| mem_rd_req | output | 1 | Level read request to the controller |
| mem_wr_req | output | 1 | Level write request to the controller |
| mem_addr | output | 32 | Held transfer address |
| mem_wdata | output | 32 | Held write data |
| mem_rdata | input | 32 | Read data from the controller |
| mem_done | input | 1 | One-cycle completion from the controller |

## Verification
If the memory-side state did not wait for the request to fall, the controller would see a second access for one launch. The access counter would show this within a few memory cycles of mem_done. If the processor side did not gate on the falling acknowledge, the next launch would be accepted early, or a second cpu_done would appear during the same transfer. A holding register that reloads while busy shows up at once as a wrong mem_addr or direction at the next access. Read data taken too early shows up as a mismatch when cpu_done fires. Mixed read/write traffic runs at 2:1, 3:1 and a non-integer ratio to expose each of these.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef enum logic [1:0] {
    CPU_IDLE     = 2'd0,
    CPU_WAIT_ACK = 2'd1,
    CPU_WAIT_REL = 2'd2
  } cpu_st_e;

  typedef enum logic [1:0] {
    MEM_IDLE   = 2'd0,
    MEM_ACCESS = 2'd1,
    MEM_ACKED  = 2'd2
  } mem_st_e;
endpackage

// File: rtl/xmb_sync.sv
module xmb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xmb_cpu_side.sv
module xmb_cpu_side
  import xmb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_s_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          req_o,
  output logic          dir_wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  cpu_st_e       st_q, st_d;
  logic          launch;
  logic          finish;
  logic          req_d;
  logic          done_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          dir_q;
  logic [DW-1:0] rdata_q;

  assign launch = (st_q == CPU_IDLE) && (rd_i || wr_i);
  assign finish = (st_q == CPU_WAIT_ACK) && ack_s_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CPU_IDLE:     if (launch)   st_d = CPU_WAIT_ACK;
      CPU_WAIT_ACK: if (ack_s_i)  st_d = CPU_WAIT_REL;
      CPU_WAIT_REL: if (!ack_s_i) st_d = CPU_IDLE;
      default:                    st_d = CPU_IDLE;
    endcase
  end

  assign req_d  = (st_d == CPU_WAIT_ACK);
  assign done_d = finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CPU_IDLE;
      req_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      req_o  <= req_d;
      done_o <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      dir_q   <= 1'b0;
    end else if (launch) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      dir_q   <= wr_i && !rd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (finish) rdata_q <= mem_rdata_i;
  end

  assign busy_o   = (st_q != CPU_IDLE);
  assign rdata_o  = rdata_q;
  assign dir_wr_o = dir_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;

  a_r2_busy_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && (rd_i || wr_i)) |=> busy_o);

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(addr_q) && $stable(wdata_q) && $stable(dir_q)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_busy_through_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  a_r9_release_needs_low_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !ack_s_i);
endmodule

// File: rtl/xmb_mem_side.sv
module xmb_mem_side
  import xmb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s_i,
  input  logic          dir_wr_i,
  input  logic          mem_done_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o
);
  mem_st_e       st_q, st_d;
  logic          rd_d, wr_d, ack_d;
  logic          take_rdata;
  logic [DW-1:0] rdata_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MEM_IDLE:   if (req_s_i)    st_d = MEM_ACCESS;
      MEM_ACCESS: if (mem_done_i) st_d = MEM_ACKED;
      MEM_ACKED:  if (!req_s_i)   st_d = MEM_IDLE;
      default:                    st_d = MEM_IDLE;
    endcase
  end

  assign rd_d       = (st_d == MEM_ACCESS) && !dir_wr_i;
  assign wr_d       = (st_d == MEM_ACCESS) &&  dir_wr_i;
  assign ack_d      = (st_d == MEM_ACKED);
  assign take_rdata = (st_q == MEM_ACCESS) && mem_done_i && !dir_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= MEM_IDLE;
      mem_rd_o <= 1'b0;
      mem_wr_o <= 1'b0;
      ack_o    <= 1'b0;
    end else begin
      st_q     <= st_d;
      mem_rd_o <= rd_d;
      mem_wr_o <= wr_d;
      ack_o    <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (take_rdata) rdata_q <= mem_rdata_i;
  end

  assign rdata_o = rdata_q;

  a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  a_r5_drop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done_i && (mem_rd_o || mem_wr_o)) |=> !(mem_rd_o || mem_wr_o));

  a_r6_no_restart_while_acked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_o || mem_wr_o) |-> !$past(ack_o));

  a_r6_ack_until_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && req_s_i) |=> ack_o);
endmodule

// File: rtl/xclk_mem_bridge.sv
module xclk_mem_bridge #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          cpu_clk,
  input  logic          cpu_rst_n,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_busy,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  input  logic          mem_clk,
  input  logic          mem_rst_n,
  output logic          mem_rd_req,
  output logic          mem_wr_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_done
);
  logic          req_cpu;
  logic          req_mem_s;
  logic          ack_mem;
  logic          ack_cpu_s;
  logic          dir_wr;
  logic [DW-1:0] rdata_mem;

  xmb_cpu_side #(.AW(AW), .DW(DW)) u_cpu (
    .clk         (cpu_clk),
    .rst_n       (cpu_rst_n),
    .rd_i        (cpu_rd),
    .wr_i        (cpu_wr),
    .addr_i      (cpu_addr),
    .wdata_i     (cpu_wdata),
    .ack_s_i     (ack_cpu_s),
    .mem_rdata_i (rdata_mem),
    .busy_o      (cpu_busy),
    .done_o      (cpu_done),
    .rdata_o     (cpu_rdata),
    .req_o       (req_cpu),
    .dir_wr_o    (dir_wr),
    .addr_o      (mem_addr),
    .wdata_o     (mem_wdata)
  );

  xmb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (mem_clk),
    .rst_n (mem_rst_n),
    .d     (req_cpu),
    .q     (req_mem_s)
  );

  xmb_mem_side #(.DW(DW)) u_mem (
    .clk         (mem_clk),
    .rst_n       (mem_rst_n),
    .req_s_i     (req_mem_s),
    .dir_wr_i    (dir_wr),
    .mem_done_i  (mem_done),
    .mem_rdata_i (mem_rdata),
    .mem_rd_o    (mem_rd_req),
    .mem_wr_o    (mem_wr_req),
    .ack_o       (ack_mem),
    .rdata_o     (rdata_mem)
  );

  xmb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (cpu_clk),
    .rst_n (cpu_rst_n),
    .d     (ack_mem),
    .q     (ack_cpu_s)
  );

  a_r4_addr_stable: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
    (mem_rd_req || mem_wr_req) |=>
      (!(mem_rd_req || mem_wr_req) || ($stable(mem_addr) && $stable(mem_wdata))));

  a_r1_quiet_in_reset: assert property (@(posedge cpu_clk)
    !cpu_rst_n |-> (!cpu_busy && !cpu_done));
endmodule

// File: tb/xclk_mem_bridge_tb_top.sv
`timescale 1ns/1ps
module xclk_mem_bridge_tb_top;
  logic        cpu_clk = 1'b0;
  logic        mem_clk = 1'b0;
  logic        cpu_rst_n, mem_rst_n;
  logic        cpu_rd, cpu_wr;
  logic [31:0] cpu_addr, cpu_wdata;
  logic        cpu_busy, cpu_done;
  logic [31:0] cpu_rdata;
  logic        mem_rd_req, mem_wr_req;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_done;

  realtime mem_half = 4.0;
  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  int acc_cnt  = 0;
  logic [31:0] last_addr, last_wdata;
  logic        last_wr;
  logic [31:0] shadow  [0:63];
  logic [31:0] mem_arr [0:63];

  always #2.0 cpu_clk = ~cpu_clk;
  initial forever #(mem_half) mem_clk = ~mem_clk;

  xclk_mem_bridge dut_i (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_clk(mem_clk),
    .mem_rst_n(mem_rst_n), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_done(mem_done)
  );

  function automatic logic [31:0] seed_word(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge cpu_clk) if (cpu_rst_n && cpu_done) done_cnt++;

  // behavioural controller: random latency, one-cycle done pulse
  int m_st = 0;
  int m_lat = 0;
  always @(negedge mem_clk) begin
    if (!mem_rst_n) begin
      m_st = 0; mem_done = 1'b0; mem_rdata = '0;
    end else begin
      case (m_st)
        0: if (mem_rd_req || mem_wr_req) begin
             acc_cnt++;
             last_addr  = mem_addr;
             last_wdata = mem_wdata;
             last_wr    = mem_wr_req;
             m_lat = $urandom % 4;
             m_st = 1;
           end
        1: if (m_lat == 0) begin
             mem_done = 1'b1;
             if (last_wr) mem_arr[last_addr[5:0]] = last_wdata;
             else         mem_rdata = mem_arr[last_addr[5:0]];
             m_st = 2;
           end else m_lat--;
        default: begin
          mem_done = 1'b0;
          // R5: request gone one memory edge after done was seen
          chk(!(mem_rd_req || mem_wr_req), "R5", {31'd0, mem_rd_req | mem_wr_req}, 32'd0);
          m_st = 0;
        end
      endcase
    end
  end

  task automatic wait_idle();
    int n = 0;
    @(negedge cpu_clk);
    while (cpu_busy && n < 2000) begin @(negedge cpu_clk); n++; end
    if (n >= 2000) chk(1'b0, "R9 busy stuck", 32'd1, 32'd0);
  endtask

  task automatic run_req(input bit rd, input bit wr, input logic [31:0] a,
                         input logic [31:0] d, input bit poke);
    int acc0, dn0, n;
    bit exp_wr;
    exp_wr = wr && !rd;
    wait_idle();
    acc0 = acc_cnt; dn0 = done_cnt;
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    @(negedge cpu_clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    chk(cpu_busy === 1'b1, "R2", {31'd0, cpu_busy}, 32'd1);
    if (poke) begin
      // R3: launch while busy must be ignored
      cpu_wr = 1'b1; cpu_addr = a ^ 32'h15; cpu_wdata = 32'hDEAD_BEEF;
      @(negedge cpu_clk);
      cpu_rd = 1'b1; cpu_wr = 1'b0;
      @(negedge cpu_clk);
      cpu_rd = 1'b0;
    end
    n = 0;
    while (!cpu_done && n < 2000) begin @(negedge cpu_clk); n++; end
    chk(cpu_done === 1'b1, "R7 done seen", {31'd0, cpu_done}, 32'd1);
    chk(cpu_busy === 1'b1, "R9 busy at done", {31'd0, cpu_busy}, 32'd1);
    if (!exp_wr)
      chk(cpu_rdata === shadow[a[5:0]], "R8 read data", cpu_rdata, shadow[a[5:0]]);
    else
      shadow[a[5:0]] = d;
    @(negedge cpu_clk);
    chk(cpu_done === 1'b0, "R7 pulse width", {31'd0, cpu_done}, 32'd0);
    wait_idle();
    repeat (6) @(negedge cpu_clk);
    chk(done_cnt - dn0 == 1, "R7 one done", done_cnt - dn0, 32'd1);
    chk(acc_cnt - acc0 == 1, poke ? "R3 R6 one access" : "R6 one access",
        acc_cnt - acc0, 32'd1);
    chk(last_addr === a, poke ? "R3 R4 address" : "R4 address", last_addr, a);
    chk(last_wr === exp_wr, "R4 direction", {31'd0, last_wr}, {31'd0, exp_wr});
    if (exp_wr) chk(last_wdata === d, "R4 write data", last_wdata, d);
  endtask

  task automatic random_phase(input int count);
    for (int i = 0; i < count; i++) begin
      bit is_wr;
      logic [31:0] a;
      is_wr = $urandom % 2;
      a = {$urandom} & 32'h0000_0FFF;
      run_req(!is_wr, is_wr, a, $urandom, 1'b0);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      shadow[i] = seed_word(i);
      mem_arr[i] = seed_word(i);
    end
    void'($urandom(32'd4242));
    cpu_rst_n = 1'b0; mem_rst_n = 1'b0;
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    mem_done = 1'b0; mem_rdata = '0;
    repeat (5) @(negedge cpu_clk);
    // R1: quiet during reset
    chk(cpu_busy === 1'b0, "R1 busy", {31'd0, cpu_busy}, 32'd0);
    chk(cpu_done === 1'b0, "R1 done", {31'd0, cpu_done}, 32'd0);
    chk(mem_rd_req === 1'b0, "R1 mem rd", {31'd0, mem_rd_req}, 32'd0);
    chk(mem_wr_req === 1'b0, "R1 mem wr", {31'd0, mem_wr_req}, 32'd0);
    @(negedge mem_clk) mem_rst_n = 1'b1;
    @(negedge cpu_clk) cpu_rst_n = 1'b1;

    // 2:1 ratio, directed corners first
    run_req(1'b1, 1'b0, 32'h0000_0003, 32'h0, 1'b0);
    run_req(1'b0, 1'b1, 32'h0000_0003, 32'hCAFE_0001, 1'b0);
    run_req(1'b1, 1'b0, 32'h0000_0003, 32'h0, 1'b0);
    run_req(1'b1, 1'b1, 32'h0000_0007, 32'h1111_2222, 1'b0); // R4 read wins
    run_req(1'b1, 1'b0, 32'h0000_0007, 32'h0, 1'b0);
    run_req(1'b0, 1'b1, 32'h0000_0010, 32'hABCD_0010, 1'b1); // R3 poke
    run_req(1'b1, 1'b0, 32'h0000_0005, 32'h0, 1'b0);         // poked addr untouched
    random_phase(30);

    wait_idle(); mem_half = 6.0;   // 3:1
    run_req(1'b0, 1'b1, 32'h0000_0020, 32'h3333_4444, 1'b1);
    random_phase(30);

    wait_idle(); mem_half = 5.37;  // unrelated ratio
    run_req(1'b1, 1'b0, 32'h0000_0020, 32'h0, 1'b1);
    random_phase(30);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule